// File: doc/BRIEF.md
# Per-Lane Delay Sweep Calibrator

This block finds a working delay tap for every data byte lane of a memory interface by brute force. It steps a shared delay code from its lowest to its highest value. Each step moves the delay by one thirty-second of a clock period, so a 5-bit code covers one full period. For every code it first asks the memory controller to reinitialize with automatic training off. Once that is acknowledged, it asks an external tester to run a memory test and takes one pass/fail bit per lane from the result. Each lane keeps its own scoreboard of outcomes. When the sweep ends, the block scans each scoreboard, finds the longest unbroken run of passing codes, and reports the centre of that run as the lane's final code.

A second delay setting is not swept. It is driven as a fixed value for the whole of one sweep. If any lane ends a sweep without a single passing code, the block moves that fixed setting to the next value in an arithmetic list and sweeps again. It stops at the first setting for which every lane has a window, or after the last setting. The DRAM initialization, the test itself and the delay lines sit outside the block and are reached only through the request/acknowledge pairs.

Both handshakes are request pulses answered by acknowledge pulses. They have no ready/valid back-pressure: the block simply waits for as long as the acknowledge takes. The result outputs behave as a valid-only stream. `done` marks them valid, and they are held until the next accepted `start`, so a consumer that cannot take them at once loses nothing.

Top module: `dly_sweep_cal`

## Requirements
- R1: `sweep_code` takes the values 0, 1, ..., 31 in rising order, one value per step. Each step adds 1/32 of a clock period of delay. Every new fixed-delay set starts the sweep again at 0.
- R2: Each step raises `init_req` for exactly one cycle and then keeps both requests low until `init_done` is seen. `test_req` is high for one cycle, in the cycle that follows the `init_done` cycle. The next step's `init_req` is high in the cycle that follows the `test_done` cycle.
- R3: Bit i of `test_pass` is lane i's result for the current code. It is sampled only in the cycle in which `test_done` is high, and each lane's scoreboard and result are independent of the other lanes.
- R4: A lane's window is its longest run of consecutive passing codes. Of two equally long runs, the one at lower codes wins.
- R5: A lane's final code is (first + last) / 2 of its window, rounded down. Lane i's code is at `lane_code[5*i +: 5]`.
- R6: A lane with no passing code sets its bit in `lane_fail` and reports code 0.
- R7: During set k, `fix_code` equals FIX_BASE + k*FIX_STEP and holds that value for the whole sweep. A further set runs only if some lane failed. The block stops at the first set where all lanes have a window, and `win_set` gives that k.
- R8: If every set leaves some lane failing, the results of the last set are reported, with `win_set` = SETS-1.
- R9: `done` is a one-cycle pulse, 34 cycles after the cycle in which `test_done` for code 31 of the final set is high. `lane_code`, `lane_fail` and `win_set` are valid while `done` is high and hold their values until the next accepted `start`.
- R10: `start` has no effect while a calibration is in progress.
- R11: While reset is asserted, the requests, `done`, `sweep_code`, `lane_code`, `lane_fail` and `win_set` are all 0.
- R12: An accepted `start` clears `lane_code`, `lane_fail` and `win_set` to 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a calibration when idle |
| init_req | output | 1 | One-cycle request to reinitialize the controller without training |
| init_done | input | 1 | Reinitialization finished |
| test_req | output | 1 | One-cycle request to run the memory test |
| test_done | input | 1 | Memory test finished; `test_pass` is valid |
| test_pass | input | LANES | Per-lane pass bits |
| sweep_code | output | CODE_W | Delay code under test |
| fix_code | output | FIX_W | Non-swept delay value for the current set |
| done | output | 1 | Calibration finished, results valid |
| lane_code | output | LANES*CODE_W | Final code per lane, lane 0 in the low bits |
| lane_fail | output | LANES | Lane had no passing code |
| win_set | output | SET_W | Index of the set whose results are reported |

## Verification
Results are due at fixed offsets. The test request comes one cycle after the init acknowledge, and the next init request one cycle after the test acknowledge. After the last acknowledge of a sweep come 32 scan cycles, one decision cycle and then `done`, so 34 cycles in all. The responder drives acknowledges on falling edges and samples the requests one falling edge after the rising edge that moves the state. At the end of every sweep it counts falling edges and expects `done` or the next set's request on exactly the 33rd. During each wait it holds `test_pass` at the inverse of the true result, so any sampling outside the acknowledge cycle shows up as a wrong final code.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT_REQ,
    ST_INIT_WAIT,
    ST_TEST_REQ,
    ST_TEST_WAIT,
    ST_SCAN,
    ST_DECIDE,
    ST_DONE
  } dsc_state_e;

endpackage

// File: rtl/dsc_score.sv
// Per-lane pass/fail storage: one bit per lane per swept code.
module dsc_score #(
  parameter int LANES = 4,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LANES-1:0] wr_bits,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [LANES-1:0] rd_bits
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DEPTH-1:0] row;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row <= '0;
      end else if (wr_en) begin
        row[wr_idx] <= wr_bits[l];
      end
    end

    assign rd_bits[l] = row[rd_idx];
  end

endmodule

// File: rtl/dsc_lane_win.sv
// Streams one lane's scoreboard in code order and keeps the longest passing run.
module dsc_lane_win #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             bit_in,
  input  logic [IDX_W-1:0] idx,
  output logic             has_win,
  output logic [IDX_W-1:0] mid_code
);
  localparam int LEN_W = IDX_W + 1;

  logic [LEN_W-1:0] run_len;
  logic [IDX_W-1:0] run_first;
  logic [LEN_W-1:0] best_len;
  logic [IDX_W-1:0] best_first;
  logic [LEN_W-1:0] grown;
  logic [LEN_W-1:0] half_span;

  assign grown = run_len + LEN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len    <= '0;
      run_first  <= '0;
      best_len   <= '0;
      best_first <= '0;
    end else if (clr) begin
      run_len    <= '0;
      run_first  <= '0;
      best_len   <= '0;
      best_first <= '0;
    end else if (step) begin
      if (bit_in) begin
        run_len <= grown;
        if (run_len == '0) begin
          run_first <= idx;
        end
        // strictly longer only: an equal later run never displaces the earlier one
        if (grown > best_len) begin
          best_len   <= grown;
          best_first <= (run_len == '0) ? idx : run_first;
        end
      end else begin
        run_len <= '0;
      end
    end
  end

  assign has_win   = (best_len != '0);
  assign half_span = (best_len - LEN_W'(1)) >> 1;
  assign mid_code  = has_win ? (best_first + half_span[IDX_W-1:0]) : '0;

endmodule

// File: rtl/dsc_ctrl.sv
// Sequencer: init/test handshake per code, scoreboard scan, set decision.
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int SETS   = 4,
  parameter int SET_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              init_done,
  input  logic              test_done,
  input  logic              all_win,
  output logic              init_req,
  output logic              test_req,
  output logic              done,
  output logic              sb_wr,
  output logic              scan_step,
  output logic              trk_clr,
  output logic              res_latch,
  output logic              res_clr,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] scan_idx,
  output logic [SET_W-1:0]  set_idx
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [SET_W-1:0]  SET_LAST = SET_W'(SETS - 1);

  dsc_state_e st, st_n;
  logic       advance_set;

  assign advance_set = (st == ST_DECIDE) && !all_win && (set_idx != SET_LAST);

  always_comb begin
    st_n      = st;
    init_req  = 1'b0;
    test_req  = 1'b0;
    done      = 1'b0;
    sb_wr     = 1'b0;
    scan_step = 1'b0;
    trk_clr   = 1'b0;
    res_latch = 1'b0;
    res_clr   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (start) begin
          st_n    = ST_INIT_REQ;
          res_clr = 1'b1;
          trk_clr = 1'b1;
        end
      end
      ST_INIT_REQ: begin
        init_req = 1'b1;
        st_n     = ST_INIT_WAIT;
      end
      ST_INIT_WAIT: begin
        if (init_done) st_n = ST_TEST_REQ;
      end
      ST_TEST_REQ: begin
        test_req = 1'b1;
        st_n     = ST_TEST_WAIT;
      end
      ST_TEST_WAIT: begin
        if (test_done) begin
          sb_wr = 1'b1;
          st_n  = (code == CODE_MAX) ? ST_SCAN : ST_INIT_REQ;
        end
      end
      ST_SCAN: begin
        scan_step = 1'b1;
        if (scan_idx == CODE_MAX) st_n = ST_DECIDE;
      end
      ST_DECIDE: begin
        res_latch = 1'b1;
        if (advance_set) begin
          st_n    = ST_INIT_REQ;
          trk_clr = 1'b1;
        end else begin
          st_n = ST_DONE;
        end
      end
      ST_DONE: begin
        done = 1'b1;
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      code     <= '0;
      scan_idx <= '0;
      set_idx  <= '0;
    end else begin
      st <= st_n;
      if (st == ST_IDLE && start) begin
        code     <= '0;
        scan_idx <= '0;
        set_idx  <= '0;
      end
      if (st == ST_TEST_WAIT && test_done && code != CODE_MAX) begin
        code <= code + CODE_W'(1);
      end
      if (scan_step) begin
        scan_idx <= scan_idx + CODE_W'(1);
      end
      if (advance_set) begin
        set_idx <= set_idx + SET_W'(1);
        code    <= '0;
      end
    end
  end

endmodule

// File: rtl/dly_sweep_cal.sv
// Per-lane delay sweep calibrator top.
module dly_sweep_cal #(
  parameter int LANES     = 4,
  parameter int CODE_W    = 5,
  parameter int SETS      = 4,
  parameter int SET_W     = (SETS > 1) ? $clog2(SETS) : 1,
  parameter int FIX_W     = 5,
  parameter int FIX_BASE  = 2,
  parameter int FIX_STEP  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic                    init_req,
  input  logic                    init_done,
  output logic                    test_req,
  input  logic                    test_done,
  input  logic [LANES-1:0]        test_pass,
  output logic [CODE_W-1:0]       sweep_code,
  output logic [FIX_W-1:0]        fix_code,
  output logic                    done,
  output logic [LANES*CODE_W-1:0] lane_code,
  output logic [LANES-1:0]        lane_fail,
  output logic [SET_W-1:0]        win_set
);
  localparam int RES_W = LANES * CODE_W;

  logic              sb_wr, scan_step, trk_clr, res_latch, res_clr;
  logic [CODE_W-1:0] scan_idx;
  logic [SET_W-1:0]  set_idx;
  logic [LANES-1:0]  sb_col;
  logic [LANES-1:0]  lane_has;
  logic [RES_W-1:0]  lane_mid;
  logic              all_win;

  assign all_win = &lane_has;

  dsc_ctrl #(
    .CODE_W (CODE_W),
    .SETS   (SETS),
    .SET_W  (SET_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .init_done (init_done),
    .test_done (test_done),
    .all_win   (all_win),
    .init_req  (init_req),
    .test_req  (test_req),
    .done      (done),
    .sb_wr     (sb_wr),
    .scan_step (scan_step),
    .trk_clr   (trk_clr),
    .res_latch (res_latch),
    .res_clr   (res_clr),
    .code      (sweep_code),
    .scan_idx  (scan_idx),
    .set_idx   (set_idx)
  );

  dsc_score #(
    .LANES (LANES),
    .IDX_W (CODE_W)
  ) u_score (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sb_wr),
    .wr_idx  (sweep_code),
    .wr_bits (test_pass),
    .rd_idx  (scan_idx),
    .rd_bits (sb_col)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_win
    dsc_lane_win #(
      .IDX_W (CODE_W)
    ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (trk_clr),
      .step     (scan_step),
      .bit_in   (sb_col[l]),
      .idx      (scan_idx),
      .has_win  (lane_has[l]),
      .mid_code (lane_mid[l*CODE_W +: CODE_W])
    );
  end

  assign fix_code = FIX_W'(FIX_BASE) + FIX_W'(FIX_STEP) * FIX_W'(set_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_code <= '0;
      lane_fail <= '0;
      win_set   <= '0;
    end else if (res_clr) begin
      lane_code <= '0;
      lane_fail <= '0;
      win_set   <= '0;
    end else if (res_latch) begin
      lane_code <= lane_mid;
      lane_fail <= ~lane_has;
      win_set   <= set_idx;
    end
  end

endmodule

// File: rtl/dly_sweep_cal_chk.sv
module dly_sweep_cal_chk #(
  parameter int LANES  = 4,
  parameter int CODE_W = 5,
  parameter int FIX_W  = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    init_req,
  input logic                    init_done,
  input logic                    test_req,
  input logic                    done,
  input logic [CODE_W-1:0]       sweep_code,
  input logic [FIX_W-1:0]        fix_code,
  input logic [LANES*CODE_W-1:0] lane_code,
  input logic [LANES-1:0]        lane_fail
);

  a_r1_code_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sweep_code) |-> (sweep_code == $past(sweep_code) + CODE_W'(1)) || (sweep_code == '0));

  a_r2_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> !init_req);

  a_r2_test_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    test_req |=> !test_req);

  a_r2_test_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    test_req |-> $past(init_done));

  a_r7_fix_hold: assert property (@(posedge clk) disable iff (!rst_n)
    test_req |-> $stable(fix_code));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !init_req && !test_req);

  for (genvar l = 0; l < LANES; l++) begin : g_fail
    a_r6_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && lane_fail[l]) |-> (lane_code[l*CODE_W +: CODE_W] == '0));
  end

endmodule

bind dly_sweep_cal dly_sweep_cal_chk #(
  .LANES  (LANES),
  .CODE_W (CODE_W),
  .FIX_W  (FIX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_req   (init_req),
  .init_done  (init_done),
  .test_req   (test_req),
  .done       (done),
  .sweep_code (sweep_code),
  .fix_code   (fix_code),
  .lane_code  (lane_code),
  .lane_fail  (lane_fail)
);

// File: tb/dly_sweep_cal_tb.sv
`timescale 1ns/1ps
module dly_sweep_cal_tb;
  localparam int LANES    = 4;
  localparam int CODE_W   = 5;
  localparam int SETS     = 4;
  localparam int SET_W    = 2;
  localparam int FIX_W    = 5;
  localparam int FIX_BASE = 2;
  localparam int FIX_STEP = 8;
  localparam int WD       = 20000;

  typedef struct packed {
    logic [3:0][31:0] mask;
    logic [2:0]       good;
    logic [3:0][4:0]  code;
    logic [3:0]       fail;
    logic [1:0]       wset;
  } vec_t;

  // mask {lane3,lane2,lane1,lane0}; lane0 forced to fail for sets below 'good'
  localparam vec_t VEC [4] = '{
    '{mask: {32'hFFFFFFFF, 32'hF0000000, 32'h0000000F, 32'h0000FF00}, good: 3'd0,
      code: {5'd15, 5'd29, 5'd1, 5'd11}, fail: 4'b0000, wset: 2'd0},
    '{mask: {32'h00000C00, 32'h00000020, 32'h00FF000F, 32'h00000F0F}, good: 3'd2,
      code: {5'd10, 5'd5, 5'd19, 5'd1}, fail: 4'b0000, wset: 2'd2},
    '{mask: {32'h0001FFFE, 32'h00000007, 32'h80000001, 32'h00000000}, good: 3'd0,
      code: {5'd8, 5'd1, 5'd0, 5'd0}, fail: 4'b0001, wset: 2'd3},
    '{mask: {32'hFFFFFFFE, 32'h0F0F0F00, 32'hAAAAAAAA, 32'h00000030}, good: 3'd1,
      code: {5'd16, 5'd9, 5'd1, 5'd4}, fail: 4'b0000, wset: 2'd1}
  };

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    start;
  logic                    init_req, test_req, done;
  logic                    init_done, test_done;
  logic [LANES-1:0]        test_pass;
  logic [CODE_W-1:0]       sweep_code;
  logic [FIX_W-1:0]        fix_code;
  logic [LANES*CODE_W-1:0] lane_code;
  logic [LANES-1:0]        lane_fail;
  logic [SET_W-1:0]        win_set;

  int cur = 0;
  int exp_code = 0;
  int set_run = 0;
  int npass = 0;
  int ntot = 0;

  always #2 clk = ~clk;

  dly_sweep_cal #(
    .LANES(LANES), .CODE_W(CODE_W), .SETS(SETS), .SET_W(SET_W),
    .FIX_W(FIX_W), .FIX_BASE(FIX_BASE), .FIX_STEP(FIX_STEP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .init_req(init_req), .init_done(init_done),
    .test_req(test_req), .test_done(test_done), .test_pass(test_pass),
    .sweep_code(sweep_code), .fix_code(fix_code), .done(done),
    .lane_code(lane_code), .lane_fail(lane_fail), .win_set(win_set)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (ok) npass++;
    else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  // one sweep step as seen by the controller/tester model
  task automatic step();
    logic [LANES-1:0] p;
    int c;
    int d;
    int cnt;
    c = int'(sweep_code);
    chk(c == exp_code, "R1", "sweep code order", 32'(c), 32'(exp_code));
    chk(fix_code == FIX_W'(FIX_BASE + set_run * FIX_STEP), "R7", "fixed delay in set",
        32'(fix_code), 32'(FIX_BASE + set_run * FIX_STEP));
    for (int l = 0; l < LANES; l++) begin
      p[l] = VEC[cur].mask[l][c];
      if (l == 0 && set_run < int'(VEC[cur].good)) p[l] = 1'b0;
    end
    test_pass = ~p;
    d = 1 + c % 3;
    repeat (d) begin
      @(negedge clk);
      chk(!init_req && !test_req, "R2", "requests quiet before init_done",
          {30'd0, init_req, test_req}, 32'd0);
    end
    init_done = 1'b1;
    @(negedge clk);
    init_done = 1'b0;
    chk(test_req == 1'b1, "R2", "test_req one cycle after init_done", 32'(test_req), 32'd1);
    d = 1 + c % 2;
    repeat (d) @(negedge clk);
    test_pass = p;
    test_done = 1'b1;
    @(negedge clk);
    test_done = 1'b0;
    test_pass = ~p;
    exp_code++;
    if (exp_code == 32) begin
      exp_code = 0;
      set_run++;
    end
    if (c == 31) begin
      cnt = 0;
      while (!done && !init_req && cnt < 100) begin
        @(negedge clk);
        cnt++;
      end
      chk(cnt == 33, "R9", "cycles from last test_done to done or next set",
          32'(cnt), 32'd33);
    end else begin
      chk(init_req == 1'b1, "R2", "next init_req one cycle after test_done",
          32'(init_req), 32'd1);
    end
  endtask

  initial begin
    init_done = 1'b0;
    test_done = 1'b0;
    test_pass = '0;
    forever begin
      @(negedge clk);
      while (init_req) step();
    end
  end

  task automatic wait_done();
    int n;
    n = 0;
    while (!done && n < WD) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R9", "done seen before timeout", 32'(done), 32'd1);
  endtask

  task automatic run(input int v, input int mid_start);
    cur = v;
    exp_code = 0;
    set_run = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_start > 0) begin
      repeat (mid_start) @(negedge clk);
      start = 1'b1;  // R10: must be ignored mid-run
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
  endtask

  task automatic check_result(input int v, input string tag);
    for (int l = 0; l < LANES; l++) begin
      chk(lane_code[l*CODE_W +: CODE_W] == VEC[v].code[l], tag, "R3/R4/R5 lane code",
          32'(lane_code[l*CODE_W +: CODE_W]), 32'(VEC[v].code[l]));
    end
    chk(lane_fail == VEC[v].fail, (v == 2) ? "R8" : "R6", "lane fail vector",
        32'(lane_fail), 32'(VEC[v].fail));
    chk(win_set == VEC[v].wset, (v == 2) ? "R8" : "R7", "winning set",
        32'(win_set), 32'(VEC[v].wset));
    chk(set_run == int'(VEC[v].wset) + 1, "R7", "number of sets swept",
        32'(set_run), 32'(int'(VEC[v].wset) + 1));
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle only", 32'(done), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!init_req && !test_req && !done, "R11", "control outputs in reset",
        {29'd0, init_req, test_req, done}, 32'd0);
    chk(sweep_code == '0, "R11", "sweep code in reset", 32'(sweep_code), 32'd0);
    chk(lane_code == '0 && lane_fail == '0 && win_set == '0, "R11", "results in reset",
        32'(lane_code), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of vectors
    for (int v = 0; v < 4; v++) begin
      run(v, 0);
      check_result(v, "R4");
    end

    // directed: start ignored while busy
    run(0, 40);
    check_result(0, "R10");

    // directed: results held after done, then cleared by start
    repeat (20) @(negedge clk);
    chk(lane_code == VEC[0].code, "R9", "results held after done",
        32'(lane_code), 32'(VEC[0].code));
    cur = 3;
    exp_code = 0;
    set_run = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(lane_code == '0 && lane_fail == '0 && win_set == '0, "R12", "start clears results",
        32'(lane_code), 32'd0);
    wait_done();
    check_result(3, "R5");

    $display("%0d/%0d checks passed", npass, ntot);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    ntot++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    $display("%0d/%0d checks passed", npass, ntot);
    $finish;
  end

endmodule